// File: doc/BRIEF.md
# Configurable Two-Table Logic Cell

This cell is a small programmable logic element. It holds two 8-entry truth tables and one storage flip-flop, all set by a single 22-bit configuration word. The low three data inputs address both tables at once. The first table drives the carry output directly. The fourth data input can combine the two tables into one 16-entry function, so the cell covers any function of four inputs. If the two tables instead hold the carry and sum of a full adder, the cell forms one adder bit.

The configuration word is written through a parallel port that is sampled on the system clock. Loading is meant to happen while the cell is idle. The flip-flop takes its clock from a fabric clock input. That input is synchronised to the system clock. The flip-flop then updates on whichever transition the configuration selects. The configuration also sets the active level of the clock enable and of the synchronous set. A final selector chooses whether the cell output comes from the table path or from the flip-flop.

Top module: `plb2lut`

## Requirements
- R1: While `rst_n` is low, and after it is released, the configuration register is all zero and `ff_q` is 0. With that zero configuration, `cout`, `lut_out` and `blk_out` are 0.
- R2: When `cfg_we` is high at a rising `clk` edge, `cfg_word` is stored. The carry table sits in bits [7:0], with bit k addressed by index k. The sum table sits in bits [15:8], with bit 8+k addressed by index k. Control bit CBn sits in bit 16+n.
- R3: `cout` equals carry-table bit `din[2:0]`, combinationally.
- R4: When CB0 = 0, `lut_out` equals sum-table bit `din[2:0]`, and `din[3]` has no effect.
- R5: When CB0 = 1, `lut_out` is sum-table bit `din[2:0]` if `din[3]` = 1, and carry-table bit `din[2:0]` if `din[3]` = 0.
- R6: The flip-flop data is `lut_out` when CB3 = 1 and sum-table bit `din[2:0]` when CB3 = 0.
- R7: The flip-flop updates only on a transition of `fclk`. CB4 = 0 selects the 0-to-1 transition and CB4 = 1 selects the 1-to-0 transition. The update takes effect at the third rising `clk` edge after `fclk` changes. The opposite transition leaves `ff_q` unchanged.
- R8: The clock enable is active when `ce` equals CB1. On a selected transition with the enable inactive and set inactive, `ff_q` holds.
- R9: The set is active when `sr` equals CB2. On a selected transition with the set active, `ff_q` becomes 1 whatever the clock enable is.
- R10: `blk_out` equals `ff_q` when CB5 = 1 and `lut_out` when CB5 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 22 | Configuration word |
| din | input | 4 | Data inputs; [2:0] form the table index, [3] is the merge select |
| fclk | input | 1 | Fabric clock for the flip-flop |
| ce | input | 1 | Clock enable; active level set by CB1 |
| sr | input | 1 | Synchronous set; active level set by CB2 |
| lut_out | output | 1 | Table output, separate or merged |
| cout | output | 1 | Carry-table output |
| ff_q | output | 1 | Flip-flop output |
| blk_out | output | 1 | Selected cell output |

## Verification
On every cycle, the assertions check the flip-flop's behaviour around a detected fabric-clock transition:
- it holds when no transition occurs;
- the set forces a 1;
- an inactive enable holds the value;
- a detected transition lasts exactly one cycle.

They also check that the carry output stays steady while the index and the configuration are steady. The bench alone shows the table contents themselves: it sweeps all sixteen input patterns under a parity configuration, the swapped parity configuration and an adder configuration. The bench also shows the choice of clock edge, the three-cycle update latency, and the effect of complemented enable and set levels.

// File: rtl/plb2lut.sv
module plb2lut #(
  parameter int SEL_W = 3,
  localparam int TBL_W = 1 << SEL_W,
  localparam int CTL_W = 6,
  localparam int CFG_W = 2 * TBL_W + CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [SEL_W:0]   din,
  input  logic             fclk,
  input  logic             ce,
  input  logic             sr,
  output logic             lut_out,
  output logic             cout,
  output logic             ff_q,
  output logic             blk_out
);

  logic [CFG_W-1:0] cfg;
  logic [2:0]       fsync;

  wire [TBL_W-1:0] tc  = cfg[TBL_W-1:0];
  wire [TBL_W-1:0] ts  = cfg[2*TBL_W-1:TBL_W];
  wire [CTL_W-1:0] ctl = cfg[CFG_W-1:2*TBL_W];
  wire [SEL_W-1:0] idx = din[SEL_W-1:0];

  wire s_bit = ts[idx];
  assign cout    = tc[idx];
  assign lut_out = ctl[0] ? (din[SEL_W] ? s_bit : cout) : s_bit;

  wire rise   = fsync[1] & ~fsync[2];
  wire fall   = ~fsync[1] & fsync[2];
  wire evt    = ctl[4] ? fall : rise;
  wire ce_act = ~(ce ^ ctl[1]);
  wire sr_act = ~(sr ^ ctl[2]);
  wire d_ff   = ctl[3] ? lut_out : s_bit;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_we) cfg <= cfg_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsync <= '0;
      ff_q  <= 1'b0;
    end else begin
      fsync <= {fsync[1:0], fclk};
      if (evt) begin
        if (sr_act)      ff_q <= 1'b1;
        else if (ce_act) ff_q <= d_ff;
      end
    end
  end

  assign blk_out = ctl[5] ? ff_q : lut_out;

endmodule

// File: rtl/plb2lut_chk.sv
module plb2lut_chk #(
  parameter int SEL_W = 3,
  parameter int CFG_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt,
  input logic             sr_act,
  input logic             ce_act,
  input logic             ff_q,
  input logic             cout,
  input logic [SEL_W:0]   din,
  input logic [CFG_W-1:0] cfg
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(ff_q));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && sr_act) |=> ff_q);

  p_ce_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !sr_act && !ce_act) |=> $stable(ff_q));

  p_cout_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(din) && $stable(cfg)) |-> $stable(cout));

endmodule

bind plb2lut plb2lut_chk #(.SEL_W(SEL_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .sr_act(sr_act), .ce_act(ce_act),
  .ff_q(ff_q), .cout(cout), .din(din), .cfg(cfg)
);

// File: tb/plb2lut_bench.sv
module plb2lut_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [21:0] cfg_word = '0;
  logic [3:0]  din = '0;
  logic        fclk = 1'b0;
  logic        ce = 1'b0;
  logic        sr = 1'b0;
  logic        lut_out, cout, ff_q, blk_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  plb2lut u_plb2lut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .din(din), .fclk(fclk), .ce(ce), .sr(sr),
    .lut_out(lut_out), .cout(cout), .ff_q(ff_q), .blk_out(blk_out)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic load(input logic [7:0] ct, input logic [7:0] st, input logic [5:0] cb);
    @(negedge clk);
    cfg_word = {cb, st, ct};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fedge(input logic lvl, output logic mid);
    @(negedge clk);
    fclk = lvl;
    @(negedge clk);
    @(negedge clk);
    mid = ff_q;
    repeat (3) @(negedge clk);
  endtask

  task automatic sweep(input logic [7:0] ct, input logic [7:0] st, input logic mrg);
    for (int i = 0; i < 16; i++) begin
      logic [3:0] d;
      logic ec, es, el;
      d  = 4'(i);
      @(negedge clk);
      din = d;
      #1;
      ec = ct[d[2:0]];
      es = st[d[2:0]];
      el = mrg ? (d[3] ? es : ec) : es;
      chk("R3 carry table", cout, ec);
      if (mrg) chk("R5 merged table", lut_out, el);
      else     chk("R4 sum table, d3 ignored", lut_out, el);
    end
  endtask

  initial begin
    logic m;
    repeat (3) @(negedge clk);
    chk("R1 ff_q reset", ff_q, 1'b0);
    chk("R1 cout reset", cout, 1'b0);
    chk("R1 lut_out reset", lut_out, 1'b0);
    chk("R1 blk_out reset", blk_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ff_q after release", ff_q, 1'b0);

    // Config A: carry XNOR3, sum XOR3; rising edge, ce/sr active high, D from sum, out comb
    load(8'h69, 8'h96, 6'b000110);
    sweep(8'h69, 8'h96, 1'b0);
    chk("R2 R10 comb output selected", blk_out, lut_out);
    ce = 1'b1; sr = 1'b0;
    din = 4'b0001;
    fedge(1'b1, m);
    chk("R7 no update before third edge", m, 1'b0);
    chk("R6 R7 sum bit captured on rise", ff_q, 1'b1);
    din = 4'b1000;
    fedge(1'b0, m);
    chk("R7 falling transition ignored", ff_q, 1'b1);
    fedge(1'b1, m);
    chk("R6 sum bit 0 captured, d3 ignored", ff_q, 1'b0);
    ce = 1'b0; din = 4'b0001;
    fedge(1'b0, m);
    fedge(1'b1, m);
    chk("R8 inactive enable holds", ff_q, 1'b0);
    sr = 1'b1; din = 4'b0000;
    fedge(1'b0, m);
    fedge(1'b1, m);
    chk("R9 set overrides inactive enable", ff_q, 1'b1);
    sr = 1'b0; ce = 1'b1;
    fedge(1'b0, m);
    fedge(1'b1, m);
    chk("R8 active enable loads 0", ff_q, 1'b0);

    // Config B: tables swapped, merge on, ce/sr active low, D merged, falling edge, out ff
    load(8'h96, 8'h69, 6'b111001);
    sweep(8'h96, 8'h69, 1'b1);
    ce = 1'b0; sr = 1'b1; din = 4'b1000;
    fedge(1'b0, m);
    chk("R7 falling transition captured", ff_q, 1'b1);
    chk("R10 ff output selected", blk_out, 1'b1);
    din = 4'b0000;
    fedge(1'b1, m);
    chk("R7 rising transition ignored", ff_q, 1'b1);
    fedge(1'b0, m);
    chk("R6 merged carry bit captured", ff_q, 1'b0);
    chk("R10 ff output follows", blk_out, 1'b0);
    ce = 1'b1; din = 4'b1000;
    fedge(1'b1, m);
    fedge(1'b0, m);
    chk("R8 high enable inactive when CB1=0", ff_q, 1'b0);
    sr = 1'b0;
    fedge(1'b1, m);
    fedge(1'b0, m);
    chk("R9 low set active when CB2=0", ff_q, 1'b1);

    // Config C: full adder bit, carry = majority, sum = parity
    load(8'hE8, 8'h96, 6'b000000);
    for (int i = 0; i < 8; i++) begin
      logic [2:0] v;
      v = 3'(i);
      @(negedge clk);
      din = {1'b0, v};
      #1;
      chk("R3 adder carry", cout, (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]));
      chk("R4 adder sum", lut_out, ^v);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule